// File: doc/BRIEF.md
# Slot-Programmed Serial Audio Transmitter

This block sends audio bytes out on several I2S-style serial data lines under the control of a small programmable table of timeslots. A superframe is a run of timeslots, each eight bit-clock periods long. At the start of every slot, the block reads that slot's table entry. The entry may ask for the next 32-bit word from an upstream FIFO to be loaded into a four-byte holding buffer. It then names one byte of that buffer and the serial line that carries it. The byte leaves MSB first on that line. All other lines stay low for the slot.

The block acts as the word-select master. Each table entry holds a requested word-select level for every line. A requested change is deferred to a later slot boundary until the line has held its current level for at least 20 bit periods. Because every slot picks a byte and a line freely, the table decides byte order and channel interleave. A superframe can run up to 16 slots. A duplex setting caps it at 8 slots so that it stays in step with a capture sequence.

The bit clock is generated internally at half the system clock rate. Data and word-select change only where the bit clock falls, so receivers can sample on its rising edge. If a slot asks for a word while the FIFO is empty, the buffer keeps its old contents and a sticky underrun flag is raised.

Top module: `tslot_i2s_tx`

## Requirements
- R1: While `rst` is high (synchronous, active high), on the following clock `sd_o` is 0, `ws_o` is all ones, `sck_o` is 0, `underrun_o` is 0 and `word_ready` is 0. The slot table is not cleared by reset.
- R2: `sck_o` toggles on every clock after reset, starting low. Each clock edge at which `sck_o` falls starts a new bit. Every 8th such bit, counting from the first fall after reset, starts a new slot. Slots run 0,1,...,N-1 and then wrap to 0.
- R3: N is `cfg_slots` clamped to the range 1..16, with 0 taken as 1. When `cfg_duplex` is 1, N is further capped at 8.
- R4: A slot whose byte-select field is b sends bits [8b+7:8b] of the holding buffer, MSB first. With two lines, 8 slots and a table that sends the high half of one word on line 0 and the low half on line 1, the 16-bit groups appear in time in the order 1L, 2L, 1R, 2R.
- R5: During a slot only the line named by the entry's 2-bit line field carries data. Every other bit of `sd_o` is 0.
- R6: At a slot start whose entry has its fetch bit set and while `word_valid` is high, `word_ready` is high for exactly that one clock. The word is loaded and is already used by the same slot. `word_ready` is never high without `word_valid`.
- R7: A fetch with `word_valid` low leaves the holding buffer unchanged, does not assert `word_ready`, and sets `underrun_o`, which then stays high until reset.
- R8: At each slot start, line i takes the requested level bit i only if it has held its present level for at least 20 bit periods (reset counts as satisfied). Otherwise it keeps its level and the request is tried again at the next slot start.
- R9: `sd_o` and `ws_o` change only at clock edges where `sck_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slots | input | 5 | Requested slots per superframe |
| cfg_duplex | input | 1 | Cap the superframe at 8 slots |
| tbl_we | input | 1 | Slot table write strobe |
| tbl_addr | input | 4 | Slot table entry to write |
| tbl_bsel | input | 2 | Byte select of the written entry |
| tbl_line | input | 2 | Serial line index of the written entry |
| tbl_ws | input | 4 | Requested word-select level per line |
| tbl_fetch | input | 1 | Load next word at start of this slot |
| word_valid | input | 1 | FIFO has a word |
| word_data | input | 32 | FIFO head word |
| word_ready | output | 1 | Pop strobe to the FIFO |
| sck_o | output | 1 | Bit clock |
| sd_o | output | 4 | Serial data lines |
| ws_o | output | 4 | Word-select lines |
| underrun_o | output | 1 | Sticky fetch-while-empty flag |

## Verification
The bench sweeps every combination of byte select and line on a one-slot superframe. A design that mixed up the byte lanes or routed data to the wrong line would show wrong bits or stray ones on idle lines. Full 16-slot, duplex-capped and 16-bit interleaved tables check slot wrap and the slot count. A design that ignored the duplex cap would fetch at the wrong slots, and its pop count and data would drift from the model. A table that asks for word-select toggles every 16 bits checks the 20-bit hold: without the hold-off, the first run length would come out as 16 instead of 24. An empty FIFO checks that the buffer is kept rather than overwritten and that the underrun flag stays set.

// File: rtl/tst_pkg.sv
package tst_pkg;

    localparam int LINES        = 4;
    localparam int LINE_W       = $clog2(LINES);
    localparam int MAX_SLOTS    = 16;
    localparam int SLOT_W       = $clog2(MAX_SLOTS);
    localparam int DUPLEX_SLOTS = 8;
    localparam int BYTE_W       = 8;
    localparam int WORD_BYTES   = 4;
    localparam int WORD_W       = BYTE_W * WORD_BYTES;
    localparam int BSEL_W       = $clog2(WORD_BYTES);
    localparam int BIT_IDX_W    = $clog2(BYTE_W);
    localparam int MIN_CH_BITS  = 20;
    localparam int HOLD_W       = $clog2(MIN_CH_BITS + 1);

    typedef struct packed {
        logic [BSEL_W-1:0] bsel;
        logic [LINE_W-1:0] line;
        logic [LINES-1:0]  ws_lvl;
        logic              fetch;
    } slot_entry_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                    input logic [BSEL_W-1:0] s);
        return w[s*BYTE_W +: BYTE_W];
    endfunction

    function automatic logic [SLOT_W:0] eff_slots(input logic [SLOT_W:0] req,
                                                  input logic duplex);
        logic [SLOT_W:0] lim;
        logic [SLOT_W:0] v;
        lim = duplex ? (SLOT_W+1)'(DUPLEX_SLOTS) : (SLOT_W+1)'(MAX_SLOTS);
        v   = (req == '0) ? (SLOT_W+1)'(1) : req;
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/tst_slot_table.sv
module tst_slot_table
    import tst_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  slot_entry_t       wdata,
    input  logic [SLOT_W-1:0] raddr,
    output slot_entry_t       rdata
);
    slot_entry_t mem [MAX_SLOTS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tst_sequencer.sv
module tst_sequencer
    import tst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W:0]   cfg_slots,
    input  logic              cfg_duplex,
    output logic              tick,
    output logic              boundary,
    output logic              sck,
    output logic [SLOT_W-1:0] next_slot
);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

    logic                 ph_q;
    logic [BIT_IDX_W-1:0] bit_q;
    logic [SLOT_W-1:0]    slot_q;
    logic                 run_q;
    logic [SLOT_W:0]      eff;

    assign eff      = eff_slots(cfg_slots, cfg_duplex);
    assign tick     = ph_q;
    assign sck      = ph_q;
    assign boundary = ph_q && (bit_q == LAST_BIT);

    always_comb begin
        if (!run_q || (({1'b0, slot_q} + (SLOT_W+1)'(1)) >= eff))
            next_slot = '0;
        else
            next_slot = slot_q + SLOT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= 1'b0;
            bit_q  <= LAST_BIT;
            slot_q <= '0;
            run_q  <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
            if (tick) begin
                if (boundary) begin
                    bit_q  <= '0;
                    slot_q <= next_slot;
                    run_q  <= 1'b1;
                end else begin
                    bit_q <= bit_q + BIT_IDX_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/tst_word_buf.sv
module tst_word_buf
    import tst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic [WORD_W-1:0] word_view,
    output logic              underrun
);
    logic [WORD_W-1:0] hold_q;
    logic              under_q;

    assign word_ready = load_req && word_valid;
    assign word_view  = word_ready ? word_data : hold_q;
    assign underrun   = under_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            under_q <= 1'b0;
        end else begin
            if (word_ready) hold_q <= word_data;
            if (load_req && !word_valid) under_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tst_ws_ctrl.sv
module tst_ws_ctrl
    import tst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             boundary,
    input  logic [LINES-1:0] want,
    output logic [LINES-1:0] ws
);
    localparam logic [HOLD_W-1:0] HOLD_MIN = HOLD_W'(MIN_CH_BITS);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [HOLD_W-1:0] held_q;
        logic              lvl_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q  <= 1'b1;
                held_q <= HOLD_MIN;
            end else if (tick) begin
                if (boundary && (want[i] != lvl_q) && (held_q >= HOLD_MIN)) begin
                    lvl_q  <= want[i];
                    held_q <= HOLD_W'(1);
                end else if (held_q < HOLD_MIN) begin
                    held_q <= held_q + HOLD_W'(1);
                end
            end
        end

        assign ws[i] = lvl_q;
    end
endmodule

// File: rtl/tslot_i2s_tx.sv
module tslot_i2s_tx
    import tst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W:0]   cfg_slots,
    input  logic              cfg_duplex,
    input  logic              tbl_we,
    input  logic [SLOT_W-1:0] tbl_addr,
    input  logic [BSEL_W-1:0] tbl_bsel,
    input  logic [LINE_W-1:0] tbl_line,
    input  logic [LINES-1:0]  tbl_ws,
    input  logic              tbl_fetch,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              sck_o,
    output logic [LINES-1:0]  sd_o,
    output logic [LINES-1:0]  ws_o,
    output logic              underrun_o
);
    logic              tick;
    logic              boundary;
    logic [SLOT_W-1:0] next_slot;
    slot_entry_t       wr_entry;
    slot_entry_t       cur;
    logic [WORD_W-1:0] word_view;
    logic [BYTE_W-1:0] shreg_q;
    logic [LINE_W-1:0] line_q;

    assign wr_entry = '{bsel: tbl_bsel, line: tbl_line, ws_lvl: tbl_ws, fetch: tbl_fetch};

    tst_sequencer u_seq (
        .clk(clk), .rst(rst), .cfg_slots(cfg_slots), .cfg_duplex(cfg_duplex),
        .tick(tick), .boundary(boundary), .sck(sck_o), .next_slot(next_slot)
    );

    tst_slot_table u_tbl (
        .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(wr_entry),
        .raddr(next_slot), .rdata(cur)
    );

    tst_word_buf u_buf (
        .clk(clk), .rst(rst), .load_req(boundary && cur.fetch),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .word_view(word_view), .underrun(underrun_o)
    );

    tst_ws_ctrl u_ws (
        .clk(clk), .rst(rst), .tick(tick), .boundary(boundary),
        .want(cur.ws_lvl), .ws(ws_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            line_q  <= '0;
        end else if (boundary) begin
            shreg_q <= pick_byte(word_view, cur.bsel);
            line_q  <= cur.line;
        end else if (tick) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_sd
        assign sd_o[i] = (line_q == LINE_W'(i)) && shreg_q[BYTE_W-1];
    end
endmodule

// File: rtl/tst_checker.sv
module tst_checker
    import tst_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sck,
    input logic [LINES-1:0] sd,
    input logic [LINES-1:0] ws,
    input logic             word_valid,
    input logic             word_ready,
    input logic             underrun
);
    logic [LINES-1:0] ws_last;

    always_ff @(posedge clk) ws_last <= ws;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (sd == '0 && ws == '1 && !sck && !underrun && !word_ready));

    assert_sck_toggles_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sck != $past(sck)));

    assert_single_line_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sd));

    assert_pop_needs_word_R6: assert property (@(posedge clk) disable iff (rst)
        word_ready |-> (word_valid && sck));

    assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    assert_change_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(sck) |-> ($stable(sd) && $stable(ws)));

    for (genvar i = 0; i < LINES; i++) begin : g_gap
        logic [HOLD_W-1:0] gap_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                gap_q <= HOLD_W'(MIN_CH_BITS);
            end else if (ws[i] != ws_last[i]) begin
                gap_q <= '0;
            end else if (sck && gap_q < HOLD_W'(MIN_CH_BITS)) begin
                gap_q <= gap_q + HOLD_W'(1);
            end
        end

        assert_ws_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (ws[i] != ws_last[i]) |-> (gap_q >= HOLD_W'(MIN_CH_BITS)));
    end
endmodule

bind tslot_i2s_tx tst_checker u_chk (
    .clk(clk), .rst(rst), .sck(sck_o), .sd(sd_o), .ws(ws_o),
    .word_valid(word_valid), .word_ready(word_ready), .underrun(underrun_o)
);

// File: tb/sim_tslot_i2s_tx.sv
module sim_tslot_i2s_tx;
    import tst_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic [4:0]  cfg_slots = 5'd16;
    logic        cfg_duplex = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [1:0]  tbl_bsel = '0;
    logic [1:0]  tbl_line = '0;
    logic [3:0]  tbl_ws = '0;
    logic        tbl_fetch = 1'b0;
    logic        word_valid;
    logic [31:0] word_data;
    logic        word_ready, sck_o, underrun_o;
    logic [3:0]  sd_o, ws_o;

    tslot_i2s_tx u0 (.*);

    int n_tests = 0, n_fail = 0;
    logic [31:0] words [64];
    int avail = 0;
    int rd_ptr;

    always @(posedge clk) begin
        if (rst) rd_ptr <= 0;
        else if (word_ready && word_valid) rd_ptr <= rd_ptr + 1;
    end
    always_comb begin
        word_valid = (rd_ptr < avail);
        word_data  = words[rd_ptr % 64];
    end

    // bench copy of the slot table as written
    logic [1:0] t_bsel [16];
    logic [1:0] t_line [16];
    logic [3:0] t_ws [16];
    logic       t_fetch [16];

    // behavioural expectation state
    bit mon_on = 0;
    logic prev_sck = 0;
    int mk, mptr, eff, mline;
    logic [31:0] mbuf;
    logic [7:0]  mbyte;
    logic [3:0]  mws;
    int mcnt [4];
    logic munder;
    logic [3:0] last_sd, last_ws;
    logic [15:0] grp;
    logic [15:0] groups [8];
    int gcnt;
    int tog_k [8];
    int tog_n;
    logic pws0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (tick %0d)", req, what, act, exp, mk);
        end
    endtask

    task automatic model_step();
        int b = mk % 8;
        logic [3:0] exp_sd;
        if (b == 0) begin
            int s = (mk / 8) % eff;
            for (int i = 0; i < 4; i++) begin
                if (t_ws[s][i] != mws[i] && mcnt[i] >= 20) begin
                    mws[i] = t_ws[s][i];
                    mcnt[i] = 1;
                end else if (mcnt[i] < 20) mcnt[i]++;
            end
            if (t_fetch[s]) begin
                if (mptr < avail) begin mbuf = words[mptr]; mptr++; end
                else munder = 1'b1;
            end
            mbyte = mbuf[t_bsel[s]*8 +: 8];
            mline = int'(t_line[s]);
        end else begin
            for (int i = 0; i < 4; i++) if (mcnt[i] < 20) mcnt[i]++;
        end
        exp_sd = '0;
        exp_sd[mline] = mbyte[7-b];
        chk(sd_o == exp_sd, "R4/R5", "sd", sd_o, exp_sd);
        chk(ws_o == mws, "R8", "ws", ws_o, mws);
        chk(underrun_o == munder, "R7", "underrun", underrun_o, munder);
        chk(rd_ptr == mptr, "R6", "pops", rd_ptr, mptr);
        grp = {grp[14:0], sd_o[mline]};
        gcnt++;
        if (gcnt % 16 == 0 && gcnt / 16 <= 8) groups[gcnt/16 - 1] = grp;
        if (ws_o[0] != pws0 && tog_n < 8) begin tog_k[tog_n] = mk; tog_n++; end
        pws0 = ws_o[0];
        last_sd = sd_o;
        last_ws = ws_o;
        mk++;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (!sck_o && prev_sck) model_step();
            else chk(sd_o == last_sd && ws_o == last_ws, "R9", "change off sck fall",
                     {sd_o, ws_o}, {last_sd, last_ws});
        end
        prev_sck = sck_o;
    end

    task automatic wr(input int idx, input logic [1:0] bs, input logic [1:0] ln,
                      input logic [3:0] w, input logic f);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 4'(idx); tbl_bsel = bs; tbl_line = ln;
        tbl_ws = w; tbl_fetch = f;
        t_bsel[idx] = bs; t_line[idx] = ln; t_ws[idx] = w; t_fetch[idx] = f;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        mon_on = 0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic launch(input int slots, input bit duplex);
        int lim;
        cfg_slots = 5'(slots); cfg_duplex = duplex;
        lim = duplex ? 8 : 16;
        eff = (slots == 0) ? 1 : slots;
        if (eff > lim) eff = lim;
        mk = 0; mptr = 0; mbuf = '0; mbyte = '0; mline = 0; mws = 4'hf;
        for (int i = 0; i < 4; i++) mcnt[i] = 20;
        munder = 0; last_sd = '0; last_ws = 4'hf; grp = '0; gcnt = 0;
        tog_n = 0; pws0 = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1;
    endtask

    task automatic run_ticks(input int n);
        int target = mk + n;
        while (mk < target) @(negedge clk);
    endtask

    bit done = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        chk(sd_o == 4'h0 && ws_o == 4'hf && sck_o == 1'b0, "R1", "reset lines",
            {sck_o, sd_o, ws_o}, 9'h00f);
        chk(!underrun_o && !word_ready, "R1", "reset flags", {underrun_o, word_ready}, 0);

        // R4 R5 R6: exhaustive byte-select x line sweep on a one-slot superframe
        for (int b = 0; b < 4; b++) begin
            for (int l = 0; l < 4; l++) begin
                enter_reset();
                wr(0, 2'(b), 2'(l), 4'hf, 1'b1);
                for (int w = 0; w < 8; w++) words[w] = 32'h8142_C3A5 ^ (w * 32'h1357_9BDF) ^ (b << l);
                avail = 8;
                launch(1, 0);
                run_ticks(24);
            end
        end

        // R2 R8: 16 slots, fetch every 4th slot, lines rotate per word
        enter_reset();
        for (int i = 0; i < 16; i++)
            wr(i, 2'(3 - i % 4), 2'(i / 4), (i < 8) ? 4'h0 : 4'hf, (i % 4) == 0);
        for (int w = 0; w < 16; w++) words[w] = 32'hF00D_0001 + w * 32'h0102_0304;
        avail = 16;
        launch(16, 0);
        run_ticks(3 * 128);
        chk(rd_ptr == 12, "R2", "pops after three 16-slot frames", rd_ptr, 12);

        // R3: duplex caps the same table at 8 slots
        enter_reset();
        launch(16, 1);
        run_ticks(3 * 64);
        chk(rd_ptr == 6, "R3", "pops after three duplex frames", rd_ptr, 6);

        // R3: zero request behaves as one slot, large request caps at 16
        enter_reset();
        launch(0, 0);
        run_ticks(32);
        chk(rd_ptr == 4, "R3", "pops with cfg_slots=0", rd_ptr, 4);
        enter_reset();
        launch(31, 0);
        run_ticks(128);
        chk(rd_ptr == 4, "R3", "pops with cfg_slots=31", rd_ptr, 4);

        // R4: 16-bit interleave 1L 2L 1R 2R on two lines
        enter_reset();
        for (int i = 0; i < 8; i++)
            wr(i, 2'(3 - i % 4), 2'((i % 4) / 2), (i < 4) ? 4'h0 : 4'h3, (i % 4) == 0);
        words[0] = 32'h1A2B_3C4D;
        words[1] = 32'h5E6F_7081;
        avail = 2;
        launch(8, 0);
        run_ticks(64);
        chk(groups[0] == 16'h1A2B, "R4", "group 1L", groups[0], 16'h1A2B);
        chk(groups[1] == 16'h3C4D, "R4", "group 2L", groups[1], 16'h3C4D);
        chk(groups[2] == 16'h5E6F, "R4", "group 1R", groups[2], 16'h5E6F);
        chk(groups[3] == 16'h7081, "R4", "group 2R", groups[3], 16'h7081);

        // R8: toggle requested every 16 bits is held to 24
        enter_reset();
        for (int i = 0; i < 8; i++)
            wr(i, 2'(i % 4), 2'd0, ((i / 2) % 2 == 0) ? 4'he : 4'hf, i == 0);
        words[0] = 32'hDEAD_BEEF;
        avail = 1;
        launch(8, 0);
        run_ticks(128);
        chk(tog_n >= 3, "R8", "line0 toggles", tog_n, 3);
        chk(tog_k[0] == 0, "R8", "first toggle tick", tog_k[0], 0);
        chk(tog_k[1] - tog_k[0] == 24, "R8", "first run length", tog_k[1] - tog_k[0], 24);

        // R7: second fetch finds the FIFO empty
        enter_reset();
        wr(0, 2'd0, 2'd2, 4'hf, 1'b1);
        wr(1, 2'd3, 2'd1, 4'hf, 1'b0);
        words[0] = 32'hC0FF_EE11;
        avail = 1;
        launch(2, 0);
        run_ticks(16);
        chk(underrun_o == 1'b0, "R7", "no underrun before empty fetch", underrun_o, 0);
        run_ticks(32);
        chk(underrun_o == 1'b1, "R7", "underrun after empty fetch", underrun_o, 1);
        chk(rd_ptr == 1, "R7", "no pop on empty fetch", rd_ptr, 1);

        enter_reset();
        chk(underrun_o == 1'b0, "R1", "underrun cleared by reset", underrun_o, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule